// File: doc/BRIEF.md
# Two-Stage Locked Watchdog Timer

This block is a memory-mapped watchdog peripheral. It has two countdown stages that run one after the other. When the first stage runs out it can raise an interrupt. The second stage then starts from its own preload. When the second stage runs out, the block drives a reset request and sets a timeout flag. That flag survives the system reset and clears only on a power-on reset or when software clears it. A prescaler divides the bus clock down to the slow tick. Every count in both stages waits for that tick.

Software reaches the block over a simple synchronous register bus. The registers that affect the timeout are guarded by a key: the two preloads and the reload register. Software must write 0x80 and then 0x86 to the reload offset before each guarded write, and each key allows exactly one guarded write. A lock bit in the control register keeps a running watchdog from being turned off by software. A mode bit turns the block into a plain repeating timer that never requests reset.

Top module: `dual_stage_watchdog`

## Requirements
- R1: A write to a guarded register (stage-1 preload at 0x00, stage-2 preload at 0x04, reload at 0x0C) has no effect unless the key is open. Writing 0x80 and then 0x86 (low 16 bits) to 0x0C, with no other bus write between them, opens the key.
- R2: An open key admits exactly one guarded write. The next guarded write is ignored until the key is written again. Writes to non-guarded registers leave the key open.
- R3: The key sequence is cancelled by any bus write that falls between the 0x80 write and the 0x86 write. It is also cancelled when the write that follows 0x80 carries a value other than 0x86.
- R4: A keyed write to 0x0C with bit 8 set restarts the watchdog from stage 1, reloading the stage-1 count from its preload and clearing the tick divider.
- R5: Stage 1 lasts exactly its preload value in ticks. When it expires, bit 0 of the status register at 0x08 is set and drives irq_out, unless bits 1:0 of the configuration register at 0x10 are 11. Writing 1 to that status bit clears it.
- R6: Stage 2 lasts exactly its preload value in ticks. When it expires in watchdog mode, rst_out rises, provided bit 5 of the configuration register is 0. rst_out then stays high until rst_n is asserted.
- R7: Bit 9 of the register at 0x0C is a timeout flag. It is set when stage 2 expires in watchdog mode, whatever the value of bit 5. It is kept through rst_n, and it is cleared by a keyed write of 1 to bit 9 or by por_n.
- R8: In the control register at 0x14, bit 1 enables counting, bit 0 locks the block and bit 2 selects the mode. Once bit 0 is set, writes cannot clear bits 0 or 1 and cannot change bit 2 until rst_n.
- R9: With configuration bit 2 at 0, a tick occurs every 2^SLOW_LOG2 clocks. With it at 1, a tick occurs every 2^FAST_LOG2 clocks.
- R10: In timer mode (control bit 2 = 1), stage-2 expiry restarts stage 1 instead of requesting reset, and it leaves the timeout flag untouched.
- R11: A read returns data one clock after rd_en. After reset the preloads read 0x200, the configuration reads 0x03, and the control, status and flag bits read 0.
- R12: While counting is disabled, both stages hold at the start of stage 1 and no interrupt or reset is produced. Enabling starts a full stage-1 period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low system reset; clears everything except the timeout flag |
| por_n | input | 1 | Active-low power-on reset for the timeout flag |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | DATA_W | Write data |
| wr_en | input | 1 | Write strobe, one clock per write |
| rd_en | input | 1 | Read strobe, one clock per read |
| rdata | output | DATA_W | Read data, valid one clock after rd_en |
| irq_out | output | 1 | Stage-1 expiry interrupt, level |
| rst_out | output | 1 | Reset request, held until rst_n |

## Verification
The assertions assume a single bus master that raises at most one strobe per clock and uses word-aligned addresses. They also assume that por_n is never released while rst_n is held low. The stimulus changes every bus signal on the falling clock edge and issues one access per clock. It pulses por_n together with rst_n only at the start and at the very end of the run. Key, guarded and plain writes are placed so that each expiry edge falls at a known clock count after the enabling or reloading write.

// File: rtl/dual_stage_watchdog.sv
module dual_stage_watchdog #(
  parameter int PRE_W     = 20,
  parameter int SLOW_LOG2 = 15,
  parameter int FAST_LOG2 = 5,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int PRE_INIT  = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_out,
  output logic              rst_out
);
  localparam logic [ADDR_W-1:0] A_PRE1 = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_PRE2 = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_RLD  = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(8'h14);
  localparam logic [15:0] KEY_A = 16'h0080;
  localparam logic [15:0] KEY_B = 16'h0086;
  localparam logic [PRE_W-1:0] PRE_RST = PRE_W'(PRE_INIT);
  localparam logic [1:0] PH_ONE = 2'd0, PH_TWO = 2'd1, PH_DONE = 2'd2;

  logic [PRE_W-1:0]     pre1, pre2, cnt;
  logic [5:0]           cfg;
  logic                 en_q, lk_q, tmr_q;
  logic                 armed, unl;
  logic [1:0]           phase;
  logic [SLOW_LOG2-1:0] pcnt;
  logic                 irq_q, flag_q, rst_q;

  wire w_pre1 = wr_en && addr == A_PRE1;
  wire w_pre2 = wr_en && addr == A_PRE2;
  wire w_stat = wr_en && addr == A_STAT;
  wire w_rld  = wr_en && addr == A_RLD;
  wire w_cfg  = wr_en && addr == A_CFG;
  wire w_ctl  = wr_en && addr == A_CTL;
  wire prot   = w_pre1 || w_pre2 || w_rld;
  wire go     = prot && unl;
  wire key_a  = w_rld && wdata[15:0] == KEY_A;
  wire key_b  = w_rld && armed && wdata[15:0] == KEY_B;
  wire reload = go && w_rld && wdata[8];
  wire fclr   = go && w_rld && wdata[9];
  wire tick   = en_q && phase != PH_DONE &&
                (cfg[2] ? &pcnt[FAST_LOG2-1:0] : &pcnt);
  wire expire = tick && cnt <= PRE_W'(1);
  wire end1   = expire && phase == PH_ONE;
  wire end2   = expire && phase == PH_TWO;

  assign irq_out = irq_q;
  assign rst_out = rst_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      armed <= 1'b0;
      unl   <= 1'b0;
    end else if (wr_en) begin
      armed <= key_a;
      unl   <= key_b ? 1'b1 : (prot ? 1'b0 : unl);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pre1 <= PRE_RST;
      pre2 <= PRE_RST;
      cfg  <= 6'h03;
      en_q <= 1'b0;
      lk_q <= 1'b0;
      tmr_q <= 1'b0;
    end else begin
      if (go && w_pre1) pre1 <= wdata[PRE_W-1:0];
      if (go && w_pre2) pre2 <= wdata[PRE_W-1:0];
      if (w_cfg) cfg <= wdata[5:0];
      if (w_ctl) begin
        if (lk_q) en_q <= en_q | wdata[1];
        else begin
          en_q  <= wdata[1];
          lk_q  <= wdata[0];
          tmr_q <= wdata[2];
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase <= PH_ONE;
      cnt   <= PRE_RST;
      pcnt  <= '0;
    end else if (!en_q || reload) begin
      phase <= PH_ONE;
      cnt   <= pre1;
      pcnt  <= '0;
    end else if (phase != PH_DONE) begin
      pcnt <= pcnt + 1'b1;
      if (tick) begin
        if (end1) begin
          phase <= PH_TWO;
          cnt   <= pre2;
        end else if (end2 && tmr_q) begin
          phase <= PH_ONE;
          cnt   <= pre1;
        end else if (end2) phase <= PH_DONE;
        else cnt <= cnt - 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      irq_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      if (end1 && cfg[1:0] != 2'b11) irq_q <= 1'b1;
      else if (w_stat && wdata[0]) irq_q <= 1'b0;
      if (end2 && !tmr_q && !cfg[5]) rst_q <= 1'b1;
    end

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) flag_q <= 1'b0;
    else if (end2 && !tmr_q) flag_q <= 1'b1;
    else if (fclr) flag_q <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rdata <= '0;
    else if (rd_en) begin
      case (addr)
        A_PRE1:  rdata <= DATA_W'(pre1);
        A_PRE2:  rdata <= DATA_W'(pre2);
        A_STAT:  rdata <= DATA_W'(irq_q);
        A_RLD:   rdata <= DATA_W'({flag_q, 9'd0});
        A_CFG:   rdata <= DATA_W'(cfg);
        A_CTL:   rdata <= DATA_W'({tmr_q, en_q, lk_q});
        default: rdata <= '0;
      endcase
    end

  // R6: reset request is held until system reset
  p_rst_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |=> rst_q);
  // R8: lock cannot be released by software
  p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lk_q |=> lk_q);
  p_lock_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_q && en_q) |=> en_q);
  // R2: an accepted guarded write closes the key
  p_one_shot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (prot && unl) |=> !unl);
  // R5: interrupt only rises while counting is enabled
  p_irq_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(en_q));
  // R7: flag only rises after stage 2 in watchdog mode
  p_flag_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(phase == PH_TWO && !tmr_q));
endmodule

// File: tb/dual_stage_watchdog_bench.sv
module dual_stage_watchdog_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          por_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [DW-1:0] rdata;
  logic          irq_out, rst_out;

  int total = 0;
  int bad = 0;
  logic [DW-1:0] exp_q[$];
  string         tag_q[$];
  logic          rd_seen = 1'b0;

  dual_stage_watchdog #(.SLOW_LOG2(4), .FAST_LOG2(2)) u_dual_stage_watchdog (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .irq_out(irq_out),
    .rst_out(rst_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk)
    if (rd_seen && exp_q.size() > 0) chk(tag_q.pop_front(), rdata, exp_q.pop_front());

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic unlock();
    wr(8'h0C, 32'h80);
    wr(8'h0C, 32'h86);
  endtask

  task automatic setup(input int p1, input int p2);
    unlock(); wr(8'h00, p1);
    unlock(); wr(8'h04, p2);
  endtask

  task automatic hw_reset();
    rst_n = 1'b0;
    wait_n(2);
    rst_n = 1'b1;
  endtask

  task automatic clear_flag();
    unlock(); wr(8'h0C, 32'h200);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    wait_n(3);
    por_n = 1'b1; rst_n = 1'b1;
    wait_n(1);
    // R11 reset state
    rd(8'h00, 32'h200, "R11 pre1 reset");
    rd(8'h10, 32'h03, "R11 cfg reset");
    rd(8'h14, 32'h0, "R11 ctl reset");
    rd(8'h0C, 32'h0, "R11 flag reset");
    rd(8'h08, 32'h0, "R11 status reset");
    chk("R11 irq reset", irq_out, 0);
    chk("R11 rst reset", rst_out, 0);
    // R1 without key, then with key
    wr(8'h00, 32'h3);
    rd(8'h00, 32'h200, "R1 write without key ignored");
    unlock(); wr(8'h00, 32'h3);
    rd(8'h00, 32'h3, "R1 keyed write");
    // R2 one write per key
    wr(8'h00, 32'h7);
    rd(8'h00, 32'h3, "R2 second write ignored");
    unlock(); wr(8'h10, 32'h03); wr(8'h04, 32'h2); wr(8'h04, 32'h9);
    rd(8'h04, 32'h2, "R2 plain write keeps key, one guarded write");
    // R3 cancellation
    wr(8'h0C, 32'h80); wr(8'h10, 32'h03); wr(8'h0C, 32'h86); wr(8'h00, 32'h9);
    rd(8'h00, 32'h3, "R3 intervening write cancels");
    wr(8'h0C, 32'h80); wr(8'h0C, 32'h85); wr(8'h00, 32'h9);
    rd(8'h00, 32'h3, "R3 wrong second key");
    // R5 R6 R7 R9 fast tick, full timeout
    wr(8'h10, 32'h04);
    wr(8'h14, 32'h02);
    wait_n(11); chk("R5 irq before stage1 end", irq_out, 0);
    wait_n(1);  chk("R5 irq at stage1 end", irq_out, 1);
    wait_n(7);  chk("R6 rst before stage2 end", rst_out, 0);
    wait_n(1);  chk("R6 rst at stage2 end", rst_out, 1);
    rd(8'h0C, 32'h200, "R7 flag set");
    wait_n(3);  chk("R6 rst held", rst_out, 1);
    hw_reset();
    chk("R6 rst cleared by rst_n", rst_out, 0);
    rd(8'h0C, 32'h200, "R7 flag survives rst_n");
    rd(8'h00, 32'h200, "R11 preload back to default");
    clear_flag();
    rd(8'h0C, 32'h0, "R7 keyed clear");
    // R4 reload, R5 clear
    setup(3, 2); wr(8'h10, 32'h04); wr(8'h14, 32'h02);
    wait_n(6);
    unlock(); wr(8'h0C, 32'h100);
    wait_n(11); chk("R4 no irq after reload", irq_out, 0);
    wait_n(1);  chk("R4 irq full period after reload", irq_out, 1);
    wr(8'h08, 32'h1);
    chk("R5 irq cleared", irq_out, 0);
    wait_n(6);  chk("R6 rst before end after reload", rst_out, 0);
    wait_n(1);  chk("R6 rst after reload period", rst_out, 1);
    hw_reset(); clear_flag();
    // R8 lock
    setup(3, 2); wr(8'h10, 32'h04); wr(8'h14, 32'h03); wr(8'h14, 32'h00);
    rd(8'h14, 32'h3, "R8 lock ignores clear");
    wait_n(20); chk("R8 locked watchdog still fires", rst_out, 1);
    hw_reset();
    rd(8'h14, 32'h0, "R8 lock cleared by rst_n");
    clear_flag();
    // R5 interrupt disabled
    setup(3, 2); wr(8'h10, 32'h07); wr(8'h14, 32'h02);
    wait_n(12); chk("R5 int type 11 gives no irq", irq_out, 0);
    wait_n(8);  chk("R6 rst with irq disabled", rst_out, 1);
    hw_reset(); clear_flag();
    // R6 R7 reset output disabled
    setup(3, 2); wr(8'h10, 32'h24); wr(8'h14, 32'h02);
    wait_n(20); chk("R6 bit5 blocks rst", rst_out, 0);
    rd(8'h0C, 32'h200, "R7 flag set with rst blocked");
    hw_reset(); clear_flag();
    // R10 timer mode
    setup(3, 2); wr(8'h10, 32'h04); wr(8'h14, 32'h06);
    wait_n(12); chk("R10 irq in timer mode", irq_out, 1);
    wr(8'h08, 32'h1);
    wait_n(18); chk("R10 irq before second period", irq_out, 0);
    chk("R10 no rst in timer mode", rst_out, 0);
    wait_n(1);  chk("R10 stage1 restarted", irq_out, 1);
    rd(8'h0C, 32'h0, "R10 no flag in timer mode");
    hw_reset();
    // R12 disabled holds
    setup(2, 1); wr(8'h10, 32'h04);
    wait_n(50);
    chk("R12 no irq while disabled", irq_out, 0);
    chk("R12 no rst while disabled", rst_out, 0);
    wr(8'h14, 32'h02);
    wait_n(7);  chk("R12 full period after enable", irq_out, 0);
    wait_n(1);  chk("R12 irq after enable period", irq_out, 1);
    hw_reset();
    // R9 slow tick
    setup(2, 1); wr(8'h10, 32'h00); wr(8'h14, 32'h02);
    wait_n(31); chk("R9 slow tick irq not yet", irq_out, 0);
    wait_n(1);  chk("R9 slow tick irq", irq_out, 1);
    wait_n(15); chk("R9 slow tick rst not yet", rst_out, 0);
    wait_n(1);  chk("R9 slow tick rst", rst_out, 1);
    // R7 power-on reset clears flag
    por_n = 1'b0; rst_n = 1'b0;
    wait_n(2);
    por_n = 1'b1; rst_n = 1'b1;
    rd(8'h0C, 32'h0, "R7 por_n clears flag");
    wait_n(2);
    chk("scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule